// File: doc/BRIEF.md
# Serial Configuration Write Port

This block is the device-side receiver of a write-only, three-wire control port. A host drives a serial clock, a serial data line and an active-low select. While the select is low, the block takes one data bit on every rising serial clock edge, assembles 24-bit words and commits each complete word to a small register file. A word carries an 8-bit address followed by 16 bits of data, both most significant bit first. One select window may carry any number of words back to back. A trailing fragment shorter than 24 bits is dropped when the select rises.

All serial inputs are brought into the system clock domain through two-flop synchronizers, and every decision is taken there. The serial clock may therefore run at any rate from a few hertz up to well below the system clock, with a loose duty cycle. Only four addresses are decoded. Words aimed anywhere else change nothing.

The register outputs drive the rest of the chip directly. A one-cycle write strobe, together with the written address, flags each committed word. A reset request bit in the control register clears itself one cycle after it is set, which gives a single-cycle soft reset pulse. A write to the input-routing register raises an apply event in the same cycle that the new routing value appears, so the change takes effect at the end of that word with no further command.

Top module: `ser_reg_write_port`

## Requirements
- R1: After reset, all four registers read 0x0000, and soft_rst_o, wr_stb_o and route_apply_o are low.
- R2: A 24-bit word is taken MSB first: the first 8 bits are the address and the next 16 bits are the data. The data lands in the register decoded at that address: 0x00 control, 0x31 mode, 0x2A gain, 0x3A route.
- R3: Several consecutive words inside one select-low window are each committed, in order.
- R4: When the select rises after fewer than 24 bits of a word, that fragment is discarded, and the next window starts a new word at bit 0.
- R5: A word to any address other than the four decoded ones changes no register and raises no write strobe.
- R6: Writing the control register with bit 0 set raises soft_rst_o for exactly one system clock cycle. Control bit 0 then reads 0, and the other control bits keep the written value.
- R7: route_apply_o pulses once for each write to the route register, in the same cycle that route_q first shows the new value. It never pulses for writes to other addresses.
- R8: Each committed word to a decoded address raises wr_stb_o for exactly one cycle, with wr_addr_o holding that address.
- R9: Serial clock edges and data while the select is high are ignored, and they do not advance the bit position of a later word.
- R10: Correct words are received with a slow serial clock and unequal high and low phases, provided each phase lasts at least three system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial clock from the host |
| ser_sel_n | input | 1 | Active-low select framing the words |
| ser_din | input | 1 | Serial data, sampled on rising ser_clk |
| ctrl_q | output | 16 | Control register; bit 0 is the self-clearing reset request |
| mode_q | output | 16 | Mode register |
| gain_q | output | 16 | Gain register |
| route_q | output | 16 | Input-routing register |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| wr_stb_o | output | 1 | One-cycle strobe per committed word |
| wr_addr_o | output | 8 | Address of the last committed word |
| route_apply_o | output | 1 | Routing apply event |

## Verification
On every cycle, the assertions check several properties. The bit position never passes 23 and returns to zero once the select is high. Completed words are never back to back. The reset request bit never lasts longer than one cycle. The routing event only comes with a strobe for the route address. No register changes without a strobe. The scenarios alone show that the bits are put together in the right order and reach the right register. They also cover these cases: several words in one window, a discarded fragment, words to unused addresses, serial clock activity while the select is high, and slow or lopsided serial clocks. Each of these depends on a whole serial sequence, not on a relation between neighbouring cycles.

// File: rtl/ser_reg_pkg.sv
`timescale 1ns/1ps
package ser_reg_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int NREG   = 4;

  localparam int IDX_CTRL  = 0;
  localparam int IDX_MODE  = 1;
  localparam int IDX_GAIN  = 2;
  localparam int IDX_ROUTE = 3;

  localparam logic [ADDR_W-1:0] REG_MAP [NREG] = '{8'h00, 8'h31, 8'h2A, 8'h3A};

  // one-hot register select, all zero for an unmapped address
  function automatic logic [NREG-1:0] decode_addr(input logic [ADDR_W-1:0] a);
    logic [NREG-1:0] hit;
    hit = '0;
    for (int i = 0; i < NREG; i++) begin
      if (a == REG_MAP[i]) hit[i] = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/ser_in_sync.sv
`timescale 1ns/1ps
module ser_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_sel_n,
  input  logic ser_din,
  output logic sclk_rise,
  output logic sel_act,
  output logic din_s
);
  // bit order within a stage: {sel_n, sclk, din}
  localparam logic [2:0] IDLE_V = 3'b100;

  logic [2:0] stg_q [STAGES];
  logic [2:0] stg_d [STAGES];
  logic       sclk_prev_q;

  always_comb begin
    stg_d[0] = {ser_sel_n, ser_clk, ser_din};
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= IDLE_V;
        else        stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= stg_q[STAGES-1][1];
  end

  assign sclk_rise = stg_q[STAGES-1][1] & ~sclk_prev_q;
  assign sel_act   = ~stg_q[STAGES-1][2];
  assign din_s     = stg_q[STAGES-1][0];
endmodule

// File: rtl/ser_word_shifter.sv
`timescale 1ns/1ps
module ser_word_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              abort,
  input  logic              bit_in,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-2:0] sh_q, sh_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;
  logic              sh_en, word_en;

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    word_d  = word_q;
    vld_d   = 1'b0;
    sh_en   = 1'b0;
    word_en = 1'b0;
    if (abort) begin
      cnt_d = '0;
    end else if (sample) begin
      if (cnt_q == LAST) begin
        word_d  = {sh_q, bit_in};
        word_en = 1'b1;
        vld_d   = 1'b1;
        cnt_d   = '0;
      end else begin
        sh_d  = {sh_q[WORD_W-3:0], bit_in};
        sh_en = 1'b1;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign word_vld_o = vld_q;
  assign word_o     = word_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (cnt_q == '0));
  // R3
  word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
endmodule

// File: rtl/ser_reg_bank.sv
`timescale 1ns/1ps
module ser_reg_bank
  import ser_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  output logic [DATA_W-1:0] regs_o [NREG],
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              route_apply_o
);
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic [NREG-1:0]   hit;
  logic [DATA_W-1:0] reg_q [NREG];
  logic [DATA_W-1:0] reg_d [NREG];
  logic              stb_d, apply_d;

  assign addr = word[WORD_W-1 -: ADDR_W];
  assign data = word[DATA_W-1:0];
  assign hit  = decode_addr(addr);

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      reg_d[i] = reg_q[i];
      if (word_vld && hit[i]) reg_d[i] = data;
    end
    // reset request lives one cycle only
    if (!(word_vld && hit[IDX_CTRL])) reg_d[IDX_CTRL][0] = 1'b0;
    stb_d   = word_vld && (|hit);
    apply_d = word_vld && hit[IDX_ROUTE];
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q[g] <= '0;
        else        reg_q[g] <= reg_d[g];
      end
      assign regs_o[g] = reg_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb_o      <= 1'b0;
      route_apply_o <= 1'b0;
    end else begin
      wr_stb_o      <= stb_d;
      route_apply_o <= apply_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wr_addr_o <= '0;
    else if (stb_d) wr_addr_o <= addr;
  end

  // R6
  srst_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q[IDX_CTRL][0] |=> !reg_q[IDX_CTRL][0]);
  // R7
  apply_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_apply_o |-> (wr_stb_o && wr_addr_o == REG_MAP[IDX_ROUTE]));
  // R5
  no_silent_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb_o |-> ($stable(reg_q[IDX_MODE]) && $stable(reg_q[IDX_GAIN]) &&
                   $stable(reg_q[IDX_ROUTE]) && $stable(reg_q[IDX_CTRL][DATA_W-1:1])));
  // R8
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);
endmodule

// File: rtl/ser_reg_write_port.sv
`timescale 1ns/1ps
module ser_reg_write_port
  import ser_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_sel_n,
  input  logic              ser_din,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] gain_q,
  output logic [DATA_W-1:0] route_q,
  output logic              soft_rst_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              route_apply_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              sclk_rise, sel_act, din_s;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ser_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ser_clk   (ser_clk),
    .ser_sel_n (ser_sel_n),
    .ser_din   (ser_din),
    .sclk_rise (sclk_rise),
    .sel_act   (sel_act),
    .din_s     (din_s)
  );

  ser_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sample     (sclk_rise & sel_act),
    .abort      (~sel_act),
    .bit_in     (din_s),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  ser_reg_bank u_bank (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .word_vld      (word_vld),
    .word          (word),
    .regs_o        (regs),
    .wr_stb_o      (wr_stb_o),
    .wr_addr_o     (wr_addr_o),
    .route_apply_o (route_apply_o)
  );

  assign ctrl_q     = regs[IDX_CTRL];
  assign mode_q     = regs[IDX_MODE];
  assign gain_q     = regs[IDX_GAIN];
  assign route_q    = regs[IDX_ROUTE];
  assign soft_rst_o = regs[IDX_CTRL][0];

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!wr_stb_o && !route_apply_o && !soft_rst_o));
endmodule

// File: tb/test_ser_reg_write_port.sv
`timescale 1ns/1ps
module test_ser_reg_write_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_sel_n = 1'b1;
  logic ser_din = 1'b0;
  logic [15:0] ctrl_q, mode_q, gain_q, route_q;
  logic soft_rst_o, wr_stb_o, route_apply_o;
  logic [7:0] wr_addr_o;

  int checks = 0;
  int errors = 0;
  int hi_cyc = 4;
  int lo_cyc = 4;
  int n_stb = 0, n_apply = 0, n_srst = 0, n_apply_bad = 0;
  logic [7:0]  last_addr = 8'h00;
  logic [15:0] apply_val = 16'h0000;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ser_reg_write_port i_ser_reg_write_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
    .ser_din(ser_din), .ctrl_q(ctrl_q), .mode_q(mode_q), .gain_q(gain_q),
    .route_q(route_q), .soft_rst_o(soft_rst_o), .wr_stb_o(wr_stb_o),
    .wr_addr_o(wr_addr_o), .route_apply_o(route_apply_o)
  );

  always @(negedge clk) begin
    if (wr_stb_o) begin
      n_stb <= n_stb + 1;
      last_addr <= wr_addr_o;
    end
    if (route_apply_o) begin
      n_apply <= n_apply + 1;
      apply_val <= route_q;
      if (wr_addr_o != 8'h3A) n_apply_bad <= n_apply_bad + 1;
    end
    if (soft_rst_o) n_srst <= n_srst + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr_cnt();
    @(posedge clk); #2;
    n_stb = 0; n_apply = 0; n_srst = 0; n_apply_bad = 0;
  endtask

  task automatic send_bits(input logic [23:0] v, input int n);
    for (int i = 23; i > 23 - n; i--) begin
      ser_din = v[i];
      ser_clk = 1'b0;
      cyc(lo_cyc);
      ser_clk = 1'b1;
      cyc(hi_cyc);
    end
    ser_clk = 1'b0;
    cyc(lo_cyc);
  endtask

  task automatic open_win();
    ser_sel_n = 1'b0;
    cyc(lo_cyc);
  endtask

  task automatic close_win();
    ser_sel_n = 1'b1;
    cyc(12);
  endtask

  task automatic write_one(input logic [7:0] a, input logic [15:0] d);
    open_win();
    send_bits({a, d}, 24);
    close_win();
  endtask

  task automatic t_reset();
    chk(ctrl_q == 0 && mode_q == 0 && gain_q == 0 && route_q == 0, "R1 regs", {ctrl_q, mode_q}, 0);
    chk(!soft_rst_o && !wr_stb_o && !route_apply_o, "R1 pulses",
        {soft_rst_o, wr_stb_o, route_apply_o}, 0);
  endtask

  task automatic t_single();
    clr_cnt();
    write_one(8'h31, 16'hC35A);
    chk(mode_q == 16'hC35A, "R2 mode data", mode_q, 16'hC35A);
    chk(gain_q == 0 && route_q == 0, "R2 others untouched", {gain_q, route_q}, 0);
    chk(n_stb == 1 && last_addr == 8'h31, "R8 strobe", {n_stb[15:0], 8'h0, last_addr}, 32'h0001_0031);
    chk(n_apply == 0, "R7 no apply for mode", n_apply, 0);
  endtask

  task automatic t_multi();
    clr_cnt();
    open_win();
    send_bits({8'h2A, 16'h1234}, 24);
    send_bits({8'h31, 16'h0F0F}, 24);
    send_bits({8'h2A, 16'hBEEF}, 24);
    close_win();
    chk(gain_q == 16'hBEEF, "R3 last gain", gain_q, 16'hBEEF);
    chk(mode_q == 16'h0F0F, "R3 mode in window", mode_q, 16'h0F0F);
    chk(n_stb == 3, "R3 three strobes", n_stb, 3);
  endtask

  task automatic t_partial();
    clr_cnt();
    open_win();
    send_bits({8'h2A, 16'h5555}, 24);
    send_bits({8'h31, 16'hFFFF}, 10);
    close_win();
    chk(gain_q == 16'h5555, "R4 full word kept", gain_q, 16'h5555);
    chk(mode_q == 16'h0F0F, "R4 fragment dropped", mode_q, 16'h0F0F);
    chk(n_stb == 1, "R4 one strobe", n_stb, 1);
    write_one(8'h31, 16'h00A1);
    chk(mode_q == 16'h00A1, "R4 fresh word after fragment", mode_q, 16'h00A1);
  endtask

  task automatic t_undef();
    clr_cnt();
    open_win();
    send_bits({8'h01, 16'hFFFF}, 24);
    send_bits({8'hFF, 16'hFFFF}, 24);
    send_bits({8'h3B, 16'hFFFF}, 24);
    close_win();
    chk(ctrl_q == 0 && mode_q == 16'h00A1 && gain_q == 16'h5555 && route_q == 0,
        "R5 regs unchanged", {mode_q, gain_q}, 32'h00A1_5555);
    chk(n_stb == 0, "R5 no strobe", n_stb, 0);
    chk(n_srst == 0, "R5 no soft reset", n_srst, 0);
  endtask

  task automatic t_soft_rst();
    clr_cnt();
    write_one(8'h00, 16'h00A5);
    chk(n_srst == 1, "R6 one-cycle pulse", n_srst, 1);
    chk(ctrl_q == 16'h00A4, "R6 bit0 cleared, rest kept", ctrl_q, 16'h00A4);
    chk(!soft_rst_o, "R6 pulse low", soft_rst_o, 0);
    clr_cnt();
    write_one(8'h00, 16'h0002);
    chk(n_srst == 0 && ctrl_q == 16'h0002, "R6 no pulse bit0 clear", {n_srst[15:0], ctrl_q}, 32'h0000_0002);
  endtask

  task automatic t_route();
    clr_cnt();
    open_win();
    send_bits({8'h3A, 16'h00E4}, 24);
    send_bits({8'h2A, 16'h0101}, 24);
    send_bits({8'h3A, 16'h001B}, 24);
    close_win();
    chk(n_apply == 2, "R7 apply count", n_apply, 2);
    chk(apply_val == 16'h001B, "R7 value visible with apply", apply_val, 16'h001B);
    chk(route_q == 16'h001B && n_apply_bad == 0, "R7 route value", route_q, 16'h001B);
  endtask

  task automatic t_idle_sclk();
    clr_cnt();
    for (int i = 0; i < 30; i++) begin
      ser_din = i[0];
      ser_clk = 1'b1; cyc(4);
      ser_clk = 1'b0; cyc(4);
    end
    cyc(10);
    chk(n_stb == 0, "R9 no strobe while deselected", n_stb, 0);
    write_one(8'h2A, 16'h7E81);
    chk(gain_q == 16'h7E81, "R9 word aligned after idle clocks", gain_q, 16'h7E81);
  endtask

  task automatic t_slow();
    clr_cnt();
    hi_cyc = 3; lo_cyc = 41;
    write_one(8'h31, 16'h9669);
    chk(mode_q == 16'h9669, "R10 lopsided slow clock", mode_q, 16'h9669);
    hi_cyc = 120; lo_cyc = 3;
    write_one(8'h3A, 16'h0C30);
    chk(route_q == 16'h0C30 && n_apply == 1, "R10 long high phase", route_q, 16'h0C30);
    hi_cyc = 4; lo_cyc = 4;
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_single();
    t_multi();
    t_partial();
    t_undef();
    t_soft_rst();
    t_route();
    t_idle_sclk();
    t_slow();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule